// File: doc/BRIEF.md
# Dual-Mode PWM Generator with Cycle Trip

This block drives one PWM output from a free-running counter in one of two shapes. In sawtooth mode the counter climbs from zero to the period minus one and wraps. The output is active from the first cycle of each period until the count reaches the duty value. In triangle mode the counter climbs and then descends through the same values, so the active stretch sits symmetrically about the middle of a period of twice the length.

Period, duty and mode are presented on buffered inputs and are copied into working registers only at a period boundary. A one-clock `sample_taken` flag marks the first cycle that runs on the new values, which tells the feeding logic that it may present the next sample. In sawtooth mode a `trip` input, for example from an over-current comparator, forces the output inactive for the rest of the running period. In triangle mode the trip input is ignored. An `invert` input flips the output polarity, and a trip always drives the inactive level of the chosen polarity.

The sequencer is a small state machine with three named states. `ST_SAW` counts up and wraps (transition *saw_wrap*). `ST_UP` climbs to the top count (transition *peak*, to `ST_DN`, with the count held). `ST_DN` descends to zero (transition *valley_wrap*). A wrap takes the state given by the buffered mode: `ST_SAW` or `ST_UP`. Reset enters `ST_SAW` with period 1 and duty 0, so the first clock after reset is a boundary.

Top module: `pwm_trip_gen`

## Requirements
- R1: While reset is held, `pwm_out` is 0 (with `invert` low) and `sample_taken` is 0. The first clock edge after reset release loads the buffered inputs.
- R2: In sawtooth mode a period lasts P cycles, where P is the loaded `per_buf` value and a value of 0 counts as 1. The output is active during the first D cycles of each period, where D is the loaded `duty_buf` value.
- R3: In triangle mode (`tri_mode`=1) the count runs 0,1..P-1 and then P-1..1,0, so the period lasts 2P cycles. The output is active in each cycle where count+D >= P, which gives 2D active cycles centred in the period.
- R4: `sample_taken` is high for exactly the first cycle of every period, which is the cycle after the edge where the buffered values were copied.
- R5: In sawtooth mode, `trip` high at any clock edge other than the last edge of a period forces the output inactive from the next cycle to the end of that period. The new period starts untripped.
- R6: In triangle mode `trip` has no effect on the output.
- R7: D=0 gives a constant inactive output. D >= P gives a constant active output when no trip is in force.
- R8: `invert`=1 flips the output level. The level forced by a trip equals the value of `invert`.
- R9: `per_buf`, `duty_buf` and `tri_mode` are sampled only at the last edge of a period. Changes at other times do not affect the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tri_mode | input | 1 | Buffered mode select: 1 = triangle, 0 = sawtooth |
| invert | input | 1 | Output polarity inversion, applied live |
| per_buf | input | CW | Buffered period value P |
| duty_buf | input | CW | Buffered duty value D |
| trip | input | 1 | Cycle abort request, acts in sawtooth mode only |
| pwm_out | output | 1 | PWM output |
| sample_taken | output | 1 | One-cycle pulse when buffered values are taken |

## Verification
The hardest case to reach from the ports is a trip or a buffer change that lands on a period boundary. The trip sampled at the last edge must not carry into the next period. A mid-period change must wait for the wrap, while a change at the wrap edge must take effect at once. Short random periods of one to a few cycles make boundaries frequent. The bench toggles `trip` and the buffered inputs at random on every cycle. A cycle-level reference model tracks the position within each period and decides which values the wrap edge captured.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_SAW = 2'd0,
        ST_UP  = 2'd1,
        ST_DN  = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/pwm_seq.sv
// Counter sequencer: state register, count and double-buffer capture.
module pwm_seq
    import pwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tri_in,
    input  logic [CW-1:0] per_in,
    input  logic [CW-1:0] duty_in,
    output pwm_state_e    state,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] pw,
    output logic [CW-1:0] dw,
    output logic          wrap,
    output logic          taken
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    pwm_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] pw_q, dw_q;
    logic          taken_q;
    logic          wrap_c;

    // next-state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap_c  = 1'b0;
        unique case (state_q)
            ST_SAW: begin
                if (cnt_q == pw_q - ONE) wrap_c = 1'b1;
                else                     cnt_d  = cnt_q + ONE;
            end
            ST_UP: begin
                if (cnt_q == pw_q - ONE) state_d = ST_DN;
                else                     cnt_d   = cnt_q + ONE;
            end
            ST_DN: begin
                if (cnt_q == ZERO) wrap_c = 1'b1;
                else               cnt_d  = cnt_q - ONE;
            end
            default: wrap_c = 1'b1;
        endcase
        if (wrap_c) begin
            state_d = tri_in ? ST_UP : ST_SAW;
            cnt_d   = ZERO;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SAW;
            cnt_q   <= ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // working registers loaded at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_q    <= ONE;
            dw_q    <= ZERO;
            taken_q <= 1'b0;
        end else begin
            taken_q <= wrap_c;
            if (wrap_c) begin
                pw_q <= (per_in == ZERO) ? ONE : per_in;
                dw_q <= duty_in;
            end
        end
    end

    assign state = state_q;
    assign cnt   = cnt_q;
    assign pw    = pw_q;
    assign dw    = dw_q;
    assign wrap  = wrap_c;
    assign taken = taken_q;
endmodule

// File: rtl/pwm_trip.sv
// Per-period trip latch, sawtooth only.
module pwm_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic is_saw,
    input  logic boundary,
    input  logic trip_in,
    output logic trip_q
);
    logic lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        lat_q <= 1'b0;
        else if (boundary) lat_q <= 1'b0;
        else               lat_q <= lat_q | (trip_in & is_saw);
    end

    assign trip_q = lat_q;
endmodule

// File: rtl/pwm_drive.sv
// Output decode: compare, polarity, trip override.
module pwm_drive
    import pwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  pwm_state_e    state,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] pw,
    input  logic [CW-1:0] dw,
    input  logic          trip_q,
    input  logic          invert,
    output logic          pwm_out
);
    localparam int SW = CW + 1;

    logic [SW-1:0] sum;
    logic          active;

    always_comb begin
        sum = {1'b0, cnt} + {1'b0, dw};
        unique case (state)
            ST_SAW:  active = (cnt < dw);
            ST_UP,
            ST_DN:   active = (sum >= {1'b0, pw});
            default: active = 1'b0;
        endcase
        pwm_out = trip_q ? invert : (active ^ invert);
    end
endmodule

// File: rtl/pwm_trip_gen.sv
module pwm_trip_gen
    import pwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tri_mode,
    input  logic          invert,
    input  logic [CW-1:0] per_buf,
    input  logic [CW-1:0] duty_buf,
    input  logic          trip,
    output logic          pwm_out,
    output logic          sample_taken
);
    pwm_state_e    st;
    logic [CW-1:0] cnt, pw, dw;
    logic          wrap, trip_q;

    pwm_seq #(.CW(CW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tri_in (tri_mode),
        .per_in (per_buf),
        .duty_in(duty_buf),
        .state  (st),
        .cnt    (cnt),
        .pw     (pw),
        .dw     (dw),
        .wrap   (wrap),
        .taken  (sample_taken)
    );

    pwm_trip u_trip (
        .clk     (clk),
        .rst_n   (rst_n),
        .is_saw  (st == ST_SAW),
        .boundary(wrap),
        .trip_in (trip),
        .trip_q  (trip_q)
    );

    pwm_drive #(.CW(CW)) u_drive (
        .state  (st),
        .cnt    (cnt),
        .pw     (pw),
        .dw     (dw),
        .trip_q (trip_q),
        .invert (invert),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_trip_gen_chk.sv
module pwm_trip_gen_chk
    import pwm_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input pwm_state_e    state,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] pw,
    input logic [CW-1:0] dw,
    input logic          trip_q,
    input logic          trip,
    input logic          wrap,
    input logic          taken,
    input logic          pwm_out,
    input logic          invert
);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < pw);

    // R4
    flag_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (cnt == '0 && state != ST_DN));

    // R3
    peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UP && cnt == pw - CW'(1)) |=> (state == ST_DN && $stable(cnt)));

    // R5
    trip_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAW && trip && !wrap) |=> (pwm_out == invert));

    // R6
    tri_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SAW) |-> !trip_q);

    // R7
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw == '0) |-> (pwm_out == invert));

    // R9
    hold_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(pw) && $stable(dw)));
endmodule

bind pwm_trip_gen pwm_trip_gen_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (st),
    .cnt    (cnt),
    .pw     (pw),
    .dw     (dw),
    .trip_q (trip_q),
    .trip   (trip),
    .wrap   (wrap),
    .taken  (sample_taken),
    .pwm_out(pwm_out),
    .invert (invert)
);

// File: tb/tb_pwm_trip_gen.sv
`timescale 1ns/1ps
module tb_pwm_trip_gen;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tri_mode, invert, trip;
    logic [CW-1:0] per_buf, duty_buf;
    logic          pwm_out, sample_taken;

    always #4 clk = ~clk;

    pwm_trip_gen #(.CW(CW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tri_mode    (tri_mode),
        .invert      (invert),
        .per_buf     (per_buf),
        .duty_buf    (duty_buf),
        .trip        (trip),
        .pwm_out     (pwm_out),
        .sample_taken(sample_taken)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference model
    int m_P, m_D, m_pos;
    bit m_tri, m_trip, m_flag;
    int r_pmax;

    function automatic int m_len();
        return m_tri ? 2 * m_P : m_P;
    endfunction

    function automatic bit exp_act();
        int v;
        if (!m_tri) return (m_pos < m_D);
        v = (m_pos < m_P) ? m_pos : (2 * m_P - 1 - m_pos);
        return ((v + m_D) >= m_P);
    endfunction

    task automatic model_edge();
        if (m_pos == m_len() - 1) begin
            m_P    = (per_buf == 0) ? 1 : int'(per_buf);
            m_D    = int'(duty_buf);
            m_tri  = tri_mode;
            m_pos  = 0;
            m_trip = 0;
            m_flag = 1;
        end else begin
            m_pos++;
            m_flag = 0;
            if (!m_tri && trip) m_trip = 1;
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_cycle();
        logic  e;
        string t;
        e = m_trip ? invert : (exp_act() ^ invert);
        if (m_trip)                          t = "R5";
        else if (m_tri && trip)              t = "R6";
        else if (m_D == 0 || m_D >= m_P)     t = "R7";
        else if (invert)                     t = "R8";
        else if (int'(duty_buf) != m_D || int'(per_buf) != m_P) t = "R9";
        else                                 t = m_tri ? "R3" : "R2";
        check_bit(t, pwm_out, e, "pwm_out");
        check_bit("R4", sample_taken, m_flag, "sample_taken");
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        check_cycle();
    endtask

    task automatic setv(bit md, int p, int d, bit inv);
        tri_mode = md;
        per_buf  = CW'(p);
        duty_buf = CW'(d);
        invert   = inv;
    endtask

    // n cycles with random trip and random buffer changes
    task automatic run(int n, int trip_pct, int chg_pct);
        for (int i = 0; i < n; i++) begin
            step();
            trip = ($urandom_range(99) < trip_pct);
            if ($urandom_range(99) < chg_pct) begin
                per_buf  = CW'($urandom_range(r_pmax));
                duty_buf = CW'($urandom_range(r_pmax + 2));
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        trip  = 1'b0;
        setv(0, 6, 2, 0);
        m_P = 1; m_D = 0; m_pos = 0; m_tri = 0; m_trip = 0; m_flag = 0;
        r_pmax = 8;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bit("R1", pwm_out, 1'b0, "pwm_out in reset");
        check_bit("R1", sample_taken, 1'b0, "sample_taken in reset");
        rst_n = 1'b1;

        // R2 sawtooth
        run(30, 0, 0);
        // R3 triangle
        setv(1, 5, 2, 0);
        run(40, 0, 0);
        // R7 duty extremes in both modes
        setv(0, 6, 0, 0);   run(20, 0, 0);
        setv(0, 6, 6, 0);   run(20, 0, 0);
        setv(0, 6, 200, 0); run(20, 0, 0);
        setv(1, 4, 0, 0);   run(20, 0, 0);
        setv(1, 4, 4, 0);   run(20, 0, 0);
        // R5 single trip pulse mid period
        setv(0, 10, 8, 0);
        run(12, 0, 0);
        trip = 1'b1; step(); trip = 1'b0;
        run(25, 0, 0);
        // R6 triangle with trip held
        setv(1, 6, 3, 0);
        trip = 1'b1;
        for (int i = 0; i < 40; i++) step();
        trip = 1'b0;
        // R8 inverted output, with trips
        setv(0, 7, 3, 1);
        run(60, 20, 0);
        // R9 buffer changes in mid period
        setv(0, 12, 4, 0);
        run(15, 0, 0);
        r_pmax = 12;
        run(80, 0, 40);

        // constrained random segments
        for (int s = 0; s < 70; s++) begin
            r_pmax = ($urandom_range(3) == 0) ? 40 : 6;
            tri_mode = $urandom_range(1);
            invert   = ($urandom_range(3) == 0);
            per_buf  = CW'($urandom_range(r_pmax));
            duty_buf = CW'($urandom_range(r_pmax + 2));
            run(300, 15, 10);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule